// File: doc/BRIEF.md
# Packet-Filter VM Arithmetic Unit

This unit carries out the arithmetic instruction group of a packet-filter virtual machine. Each instruction supplies four inputs:

- an 8-bit opcode;
- the 64-bit value of the destination register;
- the 64-bit value of the source register;
- a 32-bit immediate.

The unit returns the 64-bit value to be written back to the destination register.

One opcode space covers two operand widths, a 32-bit class and a 64-bit class. A single opcode bit chooses whether the second operand comes from the immediate or from the source register. Byte-order conversion acts on the destination value alone. The immediate selects its width, and one opcode bit selects its target order.

The surrounding pipeline offers an instruction with `in_valid`. The unit takes it on any clock edge where it is not busy. Most operations answer with a one-cycle `done` pulse on the next cycle, and `result` holds the value. Unsigned division and remainder use a radix-2 iterative divider that takes one quotient bit per cycle. During that time `busy` is high and further offers are ignored. Division or remainder by zero skips the divider and completes on the next cycle.

Top module: `pfvm_alu`

## Requirements
- R1: Opcode bits [2:0] equal to 3'b100 select 32-bit operation and 3'b111 select 64-bit operation. Any other class value, and operation codes 0xe and 0xf in bits [7:4], return the destination value unchanged, with `done` on the next cycle.
- R2: Opcode bit 3 set uses the source register as the second operand. Clear, it uses the immediate.
- R3: In 32-bit operation both operands are cut to their low 32 bits and the result's upper 32 bits are zero.
- R4: In 64-bit operation an immediate operand is sign-extended from bit 31.
- R5: Operation codes in bits [7:4]: 0x0 add, 0x1 subtract, 0x2 multiply (low half kept), 0x4 or, 0x5 and, 0xa xor, 0xb move (result is the second operand).
- R6: Left shift (0x6), logical right shift (0x7) and arithmetic right shift (0xc) use the second operand's low 5 bits in 32-bit operation and low 6 bits in 64-bit operation. The arithmetic shift fills with the operand's top bit (bit 31 in 32-bit operation).
- R7: Code 0x8 returns the two's-complement negation of the destination operand and ignores the second operand.
- R8: Code 0xd converts byte order of the destination value in either class. Bit 3 clear keeps the low 16, 32 or 64 bits and zero-fills above them. Bit 3 set reverses the bytes within that width and zero-fills above it. The width is the immediate value 16, 32 or 64; any other immediate returns the destination unchanged.
- R9: Code 0x3 gives the unsigned quotient and 0x9 the unsigned remainder. With a nonzero divisor, `busy` stays high for exactly 64 cycles after acceptance and `done` follows.
- R10: A zero divisor gives 0 for the quotient and the destination operand (zero-extended in 32-bit operation) for the remainder, with `done` on the next cycle.
- R11: An offer is accepted when `in_valid` is high and `busy` is low. Offers made while `busy` is high are ignored. `result` changes only together with `done`, and `done` is never high with `busy`.
- R12: After reset `busy`, `done` and `result` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction offered this cycle |
| opcode | input | 8 | Operation, source select and class |
| dst_val | input | 64 | Destination register value |
| src_val | input | 64 | Source register value |
| imm | input | 32 | Immediate field |
| busy | output | 1 | Divider running; offers ignored |
| done | output | 1 | One-cycle pulse: `result` is new |
| result | output | 64 | Value to write back |

## Verification
The bench builds the unit with its default parameters: a 64-bit datapath and a 32-bit immediate. These defaults bring the sign extension of immediates into reach, as well as all three byte-swap widths, including the full 8-byte reversal. They also give the full 64-step division, so the 64-cycle busy window and an offer made in the middle of it are both exercised. Operand values are chosen so that truncation, sign fill and carries across bit 31 give results that differ from the untruncated ones.

// File: rtl/pfvm_alu_pkg.sv
package pfvm_alu_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'h0,
    OP_SUB  = 4'h1,
    OP_MUL  = 4'h2,
    OP_DIV  = 4'h3,
    OP_OR   = 4'h4,
    OP_AND  = 4'h5,
    OP_SHL  = 4'h6,
    OP_SHR  = 4'h7,
    OP_NEG  = 4'h8,
    OP_MOD  = 4'h9,
    OP_XOR  = 4'ha,
    OP_MOV  = 4'hb,
    OP_SAR  = 4'hc,
    OP_BSWP = 4'hd
  } op_e;

  localparam logic [2:0] CLS_NARROW = 3'b100;
  localparam logic [2:0] CLS_WIDE   = 3'b111;

endpackage

// File: rtl/pfvm_opnd.sv
module pfvm_opnd #(
  parameter int DATA_W = 64,
  parameter int IMM_W  = 32,
  parameter int SH_W   = $clog2(DATA_W)
) (
  input  logic [7:0]        opcode,
  input  logic [DATA_W-1:0] dst_val,
  input  logic [DATA_W-1:0] src_val,
  input  logic [IMM_W-1:0]  imm,
  output logic              is_narrow,
  output logic              cls_ok,
  output logic [DATA_W-1:0] opa,
  output logic [DATA_W-1:0] opb,
  output logic [SH_W-1:0]   shamt
);
  import pfvm_alu_pkg::*;

  localparam int HALF_W = DATA_W / 2;

  logic [DATA_W-1:0] imm_sx;
  logic [DATA_W-1:0] b_raw;

  always_comb begin
    is_narrow = (opcode[2:0] == CLS_NARROW);
    cls_ok    = is_narrow || (opcode[2:0] == CLS_WIDE);
    imm_sx    = {{(DATA_W-IMM_W){imm[IMM_W-1]}}, imm};
    b_raw     = opcode[3] ? src_val : imm_sx;
    if (is_narrow) begin
      opa   = {{HALF_W{1'b0}}, dst_val[HALF_W-1:0]};
      opb   = {{HALF_W{1'b0}}, b_raw[HALF_W-1:0]};
      shamt = {1'b0, b_raw[SH_W-2:0]};
    end else begin
      opa   = dst_val;
      opb   = b_raw;
      shamt = b_raw[SH_W-1:0];
    end
  end

endmodule

// File: rtl/pfvm_bswap.sv
module pfvm_bswap #(
  parameter int DATA_W = 64,
  parameter int IMM_W  = 32
) (
  input  logic [DATA_W-1:0] val,
  input  logic              to_be,
  input  logic [IMM_W-1:0]  width_code,
  output logic [DATA_W-1:0] swapped,
  output logic              width_ok
);
  localparam int NB = DATA_W / 8;

  logic [DATA_W-1:0] rev16, rev32, revall;

  for (genvar k = 0; k < NB; k++) begin : g_byte
    if (k < 2) begin : g_in16
      assign rev16[8*k +: 8] = val[8*(1-k) +: 8];
    end else begin : g_out16
      assign rev16[8*k +: 8] = 8'h00;
    end
    if (k < 4) begin : g_in32
      assign rev32[8*k +: 8] = val[8*(3-k) +: 8];
    end else begin : g_out32
      assign rev32[8*k +: 8] = 8'h00;
    end
    assign revall[8*k +: 8] = val[8*(NB-1-k) +: 8];
  end

  always_comb begin
    width_ok = 1'b1;
    swapped  = val;
    case (width_code)
      IMM_W'(16):     swapped = to_be ? rev16 : {{(DATA_W-16){1'b0}}, val[15:0]};
      IMM_W'(32):     swapped = to_be ? rev32 : {{(DATA_W-32){1'b0}}, val[31:0]};
      IMM_W'(DATA_W): swapped = to_be ? revall : val;
      default:        width_ok = 1'b0;
    endcase
  end

endmodule

// File: rtl/pfvm_divider.sv
module pfvm_divider #(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DATA_W-1:0] dividend,
  input  logic [DATA_W-1:0] divisor,
  output logic              busy,
  output logic              last,
  output logic [DATA_W-1:0] quo_nxt,
  output logic [DATA_W-1:0] rem_nxt
);
  localparam int CNT_W = $clog2(DATA_W + 1);

  logic              busy_q, busy_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [DATA_W-1:0] rem_q, rem_d, quo_q, quo_d, dvs_q, dvs_d;
  logic [DATA_W:0]   shifted, diff;
  logic              upd;

  always_comb begin
    shifted = {rem_q, quo_q[DATA_W-1]};
    diff    = shifted - {1'b0, dvs_q};
    if (!diff[DATA_W]) begin
      rem_nxt = diff[DATA_W-1:0];
      quo_nxt = {quo_q[DATA_W-2:0], 1'b1};
    end else begin
      rem_nxt = shifted[DATA_W-1:0];
      quo_nxt = {quo_q[DATA_W-2:0], 1'b0};
    end
    last = busy_q && (cnt_q == CNT_W'(1));
  end

  always_comb begin
    upd    = start || busy_q;
    busy_d = busy_q;
    cnt_d  = cnt_q;
    rem_d  = rem_q;
    quo_d  = quo_q;
    dvs_d  = dvs_q;
    if (start) begin
      busy_d = 1'b1;
      cnt_d  = CNT_W'(DATA_W);
      rem_d  = '0;
      quo_d  = dividend;
      dvs_d  = divisor;
    end else if (busy_q) begin
      rem_d  = rem_nxt;
      quo_d  = quo_nxt;
      cnt_d  = cnt_q - CNT_W'(1);
      busy_d = !last;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      rem_q  <= '0;
      quo_q  <= '0;
      dvs_q  <= '0;
    end else if (upd) begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      rem_q  <= rem_d;
      quo_q  <= quo_d;
      dvs_q  <= dvs_d;
    end
  end

  assign busy = busy_q;

endmodule

// File: rtl/pfvm_alu.sv
module pfvm_alu #(
  parameter int DATA_W = 64,
  parameter int IMM_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [7:0]        opcode,
  input  logic [DATA_W-1:0] dst_val,
  input  logic [DATA_W-1:0] src_val,
  input  logic [IMM_W-1:0]  imm,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] result
);
  import pfvm_alu_pkg::*;

  localparam int HALF_W = DATA_W / 2;
  localparam int SH_W   = $clog2(DATA_W);

  logic              is_narrow, cls_ok;
  logic [DATA_W-1:0] opa, opb;
  logic [SH_W-1:0]   shamt;
  logic [DATA_W-1:0] swapped;
  logic              width_ok;
  logic              div_busy, div_last;
  logic [DATA_W-1:0] quo_nxt, rem_nxt;

  pfvm_opnd #(.DATA_W(DATA_W), .IMM_W(IMM_W), .SH_W(SH_W)) i_opnd (
    .opcode(opcode), .dst_val(dst_val), .src_val(src_val), .imm(imm),
    .is_narrow(is_narrow), .cls_ok(cls_ok), .opa(opa), .opb(opb), .shamt(shamt)
  );

  pfvm_bswap #(.DATA_W(DATA_W), .IMM_W(IMM_W)) i_bswap (
    .val(dst_val), .to_be(opcode[3]), .width_code(imm),
    .swapped(swapped), .width_ok(width_ok)
  );

  logic accept, is_div, div_zero, start_div, fast_fin;

  pfvm_divider #(.DATA_W(DATA_W)) i_div (
    .clk(clk), .rst_n(rst_n), .start(start_div), .dividend(opa), .divisor(opb),
    .busy(div_busy), .last(div_last), .quo_nxt(quo_nxt), .rem_nxt(rem_nxt)
  );

  op_e               op;
  logic [DATA_W-1:0] core, sar_src, wrap, fast_res, div_res;
  logic              pend_mod_q, pend_mod_d, pend_nar_q, pend_nar_d;
  logic              done_q, done_d;
  logic [DATA_W-1:0] res_q, res_d;
  logic              pend_en;

  always_comb begin
    op        = op_e'(opcode[7:4]);
    accept    = in_valid && !div_busy;
    is_div    = cls_ok && (op == OP_DIV || op == OP_MOD);
    div_zero  = (opb == '0);
    start_div = accept && is_div && !div_zero;
    fast_fin  = accept && !start_div;
    sar_src   = is_narrow ? {{HALF_W{opa[HALF_W-1]}}, opa[HALF_W-1:0]} : opa;

    core = opa;
    case (op)
      OP_ADD:  core = opa + opb;
      OP_SUB:  core = opa - opb;
      OP_MUL:  core = opa * opb;
      OP_DIV:  core = '0;
      OP_MOD:  core = opa;
      OP_OR:   core = opa | opb;
      OP_AND:  core = opa & opb;
      OP_XOR:  core = opa ^ opb;
      OP_MOV:  core = opb;
      OP_SHL:  core = opa << shamt;
      OP_SHR:  core = opa >> shamt;
      OP_SAR:  core = DATA_W'($signed(sar_src) >>> shamt);
      OP_NEG:  core = '0 - opa;
      default: core = opa;
    endcase
    wrap = is_narrow ? {{HALF_W{1'b0}}, core[HALF_W-1:0]} : core;

    if (!cls_ok || opcode[7:4] > 4'hd) begin
      fast_res = dst_val;
    end else if (op == OP_BSWP) begin
      fast_res = width_ok ? swapped : dst_val;
    end else begin
      fast_res = wrap;
    end

    div_res = pend_mod_q ? rem_nxt : quo_nxt;
    if (pend_nar_q) begin
      div_res = {{HALF_W{1'b0}}, div_res[HALF_W-1:0]};
    end
  end

  always_comb begin
    pend_en    = start_div;
    pend_mod_d = (op == OP_MOD);
    pend_nar_d = is_narrow;
    done_d     = fast_fin || div_last;
    res_d      = res_q;
    if (div_last) begin
      res_d = div_res;
    end else if (fast_fin) begin
      res_d = fast_res;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q     <= 1'b0;
      res_q      <= '0;
      pend_mod_q <= 1'b0;
      pend_nar_q <= 1'b0;
    end else begin
      done_q <= done_d;
      if (done_d) begin
        res_q <= res_d;
      end
      if (pend_en) begin
        pend_mod_q <= pend_mod_d;
        pend_nar_q <= pend_nar_d;
      end
    end
  end

  assign busy   = div_busy;
  assign done   = done_q;
  assign result = res_q;

endmodule

// File: rtl/pfvm_alu_chk.sv
module pfvm_alu_chk #(
  parameter int DATA_W = 64,
  parameter int IMM_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [7:0]        opcode,
  input logic [IMM_W-1:0]  imm,
  input logic              busy,
  input logic              done,
  input logic [DATA_W-1:0] result
);
  localparam int HALF_W = DATA_W / 2;
  localparam int CNT_W  = $clog2(DATA_W + 2);

  logic [CNT_W-1:0] busy_cnt;
  logic             narrow_fast;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_cnt <= '0;
    end else if (busy) begin
      busy_cnt <= busy_cnt + CNT_W'(1);
    end else begin
      busy_cnt <= '0;
    end
  end

  assign narrow_fast = (opcode[2:0] == 3'b100) && (opcode[7:4] != 4'h3) &&
                       (opcode[7:4] != 4'h9) && (opcode[7:4] < 4'hd);

  p_done_not_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_offer_answered_r11: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !busy |=> done || busy);

  p_hold_while_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> $stable(result));

  p_div_window_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> busy_cnt < CNT_W'(DATA_W));

  p_imm_sext_r4: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !busy && opcode == 8'hb7 |=>
      result == {{(DATA_W-IMM_W){$past(imm[IMM_W-1])}}, $past(imm)});

  p_upper_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !busy && narrow_fast |=> result[DATA_W-1:HALF_W] == '0);

endmodule

bind pfvm_alu pfvm_alu_chk #(.DATA_W(DATA_W), .IMM_W(IMM_W)) i_pfvm_alu_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode), .imm(imm),
  .busy(busy), .done(done), .result(result)
);

// File: tb/test_pfvm_alu.sv
module test_pfvm_alu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  opcode = '0;
  logic [63:0] dst_val = '0;
  logic [63:0] src_val = '0;
  logic [31:0] imm = '0;
  logic        busy, done;
  logic [63:0] result;
  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  pfvm_alu i_pfvm_alu (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
    .dst_val(dst_val), .src_val(src_val), .imm(imm),
    .busy(busy), .done(done), .result(result)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Offer one instruction, wait up to maxwait extra cycles for done, check result.
  task automatic run(input string tag, input logic [7:0] op, input logic [63:0] d,
                     input logic [63:0] s, input logic [31:0] i,
                     input logic [63:0] exp, input int maxwait);
    int waited = 0;
    @(negedge clk);
    opcode = op; dst_val = d; src_val = s; imm = i; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    while (!done && waited < maxwait) begin
      @(negedge clk);
      waited++;
    end
    chk({tag, " done"}, 64'(done), 64'd1);
    chk(tag, result, exp);
  endtask

  task automatic t_reset;
    chk("R12 busy", 64'(busy), 64'd0);
    chk("R12 done", 64'(done), 64'd0);
    chk("R12 result", result, 64'd0);
  endtask

  task automatic t_wide_ops;
    run("R5 add64", 8'h0f, 64'h0000_0001_FFFF_FFFF, 64'd1, 32'd0, 64'h0000_0002_0000_0000, 0);
    run("R5 mul64", 8'h2f, 64'h0000_0001_0000_0000, 64'd3, 32'd0, 64'h0000_0003_0000_0000, 0);
    run("R5 or64", 8'h4f, 64'hF000_0000_0000_000F, 64'h0F00_0000_0000_00F0, 32'd0, 64'hFF00_0000_0000_00FF, 0);
    run("R5 xor64 imm", 8'ha7, 64'h1234_5678_9ABC_DEF0, 64'd0, 32'h0000_FFFF, 64'h1234_5678_9ABC_210F, 0);
    run("R5 sub64", 8'h1f, 64'd5, 64'd7, 32'd0, 64'hFFFF_FFFF_FFFF_FFFE, 0);
  endtask

  task automatic t_narrow_ops;
    run("R3 add32 carry", 8'h0c, 64'h0000_0001_FFFF_FFFF, 64'd1, 32'd0, 64'd0, 0);
    run("R3 mul32", 8'h2c, 64'h1_0001_0000, 64'h0001_0000, 32'd0, 64'd0, 0);
    run("R3 and32", 8'h5c, 64'hFFFF_FFFF_F0F0_F0F0, 64'h0F0F_FFFF, 32'd0, 64'h0000_F0F0, 0);
    run("R3 mov32 imm", 8'hb4, 64'd0, 64'd0, 32'h8000_0000, 64'h0000_0000_8000_0000, 0);
    run("R4 mov64 imm", 8'hb7, 64'd0, 64'd0, 32'h8000_0000, 64'hFFFF_FFFF_8000_0000, 0);
    run("R4 add64 neg imm", 8'h07, 64'h10, 64'd0, 32'hFFFF_FFFF, 64'hF, 0);
  endtask

  task automatic t_src_sel;
    run("R2 imm source", 8'h07, 64'd1, 64'd100, 32'd7, 64'd8, 0);
    run("R2 reg source", 8'h0f, 64'd1, 64'd100, 32'd7, 64'd101, 0);
  endtask

  task automatic t_shifts;
    run("R6 shl64 mask", 8'h6f, 64'd1, 64'h43, 32'd0, 64'd8, 0);
    run("R6 shl32 mask", 8'h6c, 64'd1, 64'h21, 32'd0, 64'd2, 0);
    run("R6 shr64", 8'h7f, 64'h8000_0000_0000_0000, 64'd63, 32'd0, 64'd1, 0);
    run("R6 sar64", 8'hcf, 64'h8000_0000_0000_0000, 64'd4, 32'd0, 64'hF800_0000_0000_0000, 0);
    run("R6 sar32", 8'hcc, 64'h0000_0000_8000_0000, 64'd4, 32'd0, 64'h0000_0000_F800_0000, 0);
    run("R6 sar32 upper ignored", 8'hcc, 64'hFFFF_FFFF_0000_0010, 64'd1, 32'd0, 64'd8, 0);
  endtask

  task automatic t_neg;
    run("R7 neg64", 8'h87, 64'd5, 64'd77, 32'd99, 64'hFFFF_FFFF_FFFF_FFFB, 0);
    run("R7 neg32", 8'h84, 64'hAAAA_0000_0000_0005, 64'd0, 32'd0, 64'h0000_0000_FFFF_FFFB, 0);
  endtask

  task automatic t_swap;
    logic [63:0] v = 64'h1122_3344_5566_7788;
    run("R8 le16", 8'hd4, v, 64'd0, 32'd16, 64'h7788, 0);
    run("R8 le32", 8'hd4, v, 64'd0, 32'd32, 64'h5566_7788, 0);
    run("R8 le64", 8'hd4, v, 64'd0, 32'd64, v, 0);
    run("R8 be16", 8'hdc, v, 64'd0, 32'd16, 64'h8877, 0);
    run("R8 be32", 8'hdc, v, 64'd0, 32'd32, 64'h8877_6655, 0);
    run("R8 be64", 8'hdc, v, 64'd0, 32'd64, 64'h8877_6655_4433_2211, 0);
    run("R8 bad width", 8'hdc, v, 64'd0, 32'd8, v, 0);
    run("R8 wide class", 8'hdf, v, 64'd0, 32'd16, 64'h8877, 0);
  endtask

  task automatic t_div;
    run("R9 div64", 8'h3f, 64'd100, 64'd7, 32'd0, 64'd14, 64);
    run("R9 mod64", 8'h9f, 64'd100, 64'd7, 32'd0, 64'd2, 64);
    run("R9 div64 big", 8'h3f, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1_0000_0000, 32'd0, 64'hFFFF_FFFF, 64);
    run("R9 mod64 big", 8'h9f, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1_0000_0000, 32'd0, 64'hFFFF_FFFF, 64);
    run("R9 div unsigned imm", 8'h37, 64'd100, 64'd0, 32'hFFFF_FFFF, 64'd0, 64);
    run("R9 div32 trunc", 8'h3c, 64'hFFFF_FFFF_0000_0064, 64'h1_0000_000A, 32'd0, 64'd10, 64);
  endtask

  task automatic t_div_zero;
    run("R10 div by zero", 8'h3f, 64'd123, 64'd0, 32'd0, 64'd0, 0);
    run("R10 mod by zero", 8'h9f, 64'h1234_5678_9ABC_DEF0, 64'd0, 32'd0, 64'h1234_5678_9ABC_DEF0, 0);
    run("R10 mod32 by zero", 8'h9c, 64'hAAAA_BBBB_CCCC_DDDD, 64'h1_0000_0000, 32'd0, 64'h0000_0000_CCCC_DDDD, 0);
  endtask

  task automatic t_busy_ignore;
    int waited = 0;
    @(negedge clk);
    opcode = 8'h3f; dst_val = 64'd100; src_val = 64'd7; imm = '0; in_valid = 1'b1;
    @(negedge clk);
    chk("R11 busy after div accept", 64'(busy), 64'd1);
    opcode = 8'hb7; imm = 32'd5;
    repeat (3) @(negedge clk);
    in_valid = 1'b0;
    while (!done && waited < 70) begin
      @(negedge clk);
      waited++;
    end
    chk("R9 busy window", 64'(waited), 64'd61);
    chk("R11 result after ignored offer", result, 64'd14);
    @(negedge clk);
    chk("R11 single done", 64'(done), 64'd0);
    chk("R11 result held", result, 64'd14);
  endtask

  task automatic t_other_class;
    run("R1 jump class passthru", 8'h05, 64'hDEAD_BEEF_0123_4567, 64'd1, 32'd1, 64'hDEAD_BEEF_0123_4567, 0);
    run("R1 undefined op", 8'he7, 64'h0BAD_F00D_0000_0001, 64'd9, 32'd9, 64'h0BAD_F00D_0000_0001, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_wide_ops();
    t_narrow_ops();
    t_src_sel();
    t_shifts();
    t_neg();
    t_swap();
    t_div();
    t_div_zero();
    t_busy_ignore();
    t_other_class();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule